// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Layer Sequencer

This block sequences one time-step of a layer of leaky integrate-and-fire neurons held in a local memory. After `start`, it drains an input spike queue one entry at a time. Each entry stands for one presynaptic input, taken in queue order. A silent entry is thrown away without touching memory. An active entry makes the block read the weight to every output neuron, plus a synaptic gain from the table region, and fold the scaled weight into a per-neuron current register.

Once the queue is empty, the block visits each output neuron in turn. It reads the neuron's potential and a decay factor from the table region, applies the leak, adds the collected current, and decides whether the neuron fires. It then writes the potential back and pushes one spike bit per neuron into the output queue. In training mode, a neuron that fired also has the weights from every active input nudged by a table-supplied step. A one-cycle `done` pulse closes the time-step.

All values are signed Q1.7 bytes. The memory port has a one-cycle read latency. Address map with the defaults:
- weights at `i*N_OUT + j` (input `i`, neuron `j`)
- potentials at `N_IN*N_OUT + j`
- table words at `T = N_IN*N_OUT + N_OUT`: gain at T+0, decay at T+1, weight step at T+2

Top module: `snn_lif_ctrl`

## Requirements
- R1: After reset, and while idle with no `start`, `done`, `in_pop`, `out_push`, `mem_rd` and `mem_wr` are all low.
- R2: A queue entry with value 0 is popped without any memory read or write.
- R3: An active entry for input i reads the weight at i*N_OUT+j and the gain at T+0 for each neuron j. It adds sat((w*g)>>>7) into that neuron's current with saturation. `>>>` is an arithmetic shift that rounds toward minus infinity. Currents are cleared at `start`.
- R4: After the queue empties, neuron j (ascending) reads its potential v at N_IN*N_OUT+j and the decay d at T+1. It forms v' = sat(sat((v*d)>>>7) + current_j), once per time-step even with no input.
- R5: If v' > THRESH, 0 is written back and a 1 is pushed. Otherwise v' is written back and a 0 is pushed. There is one push per neuron, in neuron order.
- R6: While `out_full` is high, no push and no potential write happen; the sequencer waits, and no spike is lost.
- R7: With training off, no weight location is written.
- R8: With training on and neuron j fired, every active input i (ascending) has its weight read, the step s read at T+1+1, and sat(w+s) written back. Nothing is updated for a neuron that did not fire.
- R9: Per time-step the reads total 2*A*N_OUT + 2*N_OUT + 2*F*A and the writes N_OUT + F*A, where A is the number of active inputs and F the number of fired neurons (F counted only in training). `done` is high for exactly one cycle.
- R10: Saturation clamps every intermediate and stored value to [-128, 127] instead of wrapping.
- R11: Read data is taken from `mem_rdata` in the cycle after `mem_rd`; a read and a write never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one time-step |
| train_en | input | 1 | Enable weight updates, sampled at start |
| done | output | 1 | One-cycle end-of-time-step pulse |
| in_empty | input | 1 | Input spike queue empty |
| in_spike | input | 1 | Head entry of the input queue |
| in_pop | output | 1 | Discard the head entry |
| out_full | input | 1 | Output spike queue full |
| out_push | output | 1 | Push `out_spike` |
| out_spike | output | 1 | Fire bit of the current neuron |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |

## Verification
The bench goes after silent entries, a step with no input at all, and training runs with and without firing. A design that touched memory for a zero entry, or skipped the leak when nothing arrived, would miss the exact access counts. A design that learned in inference, or for quiet neurons, would leave changed weights. An all-negative, all-active step drives the current and potential to -128, where a wrapping adder would store a small positive value. Holding the output queue full past the first neuron shows whether a spike is dropped or a potential is written twice.

// File: rtl/snn_pkg.sv
package snn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HEAD, ST_SYN_W, ST_SYN_G, ST_SYN_ACC,
    ST_NEU_V, ST_NEU_D, ST_NEU_CAP, ST_NEU_WR,
    ST_PL_SCAN, ST_PL_W, ST_PL_D, ST_PL_CAP, ST_PL_WR, ST_DONE
  } ctl_state_t;
endpackage

// File: rtl/snn_q_mul.sv
module snn_q_mul #(
  parameter int W    = 8,
  parameter int FRAC = W - 1
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int PW   = 2 * W;
  localparam int MAXI = 2 ** (W - 1) - 1;
  localparam int MINI = -(2 ** (W - 1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shr;

  always_comb begin
    prod = PW'(a) * PW'(b);
    shr  = prod >>> FRAC;
    if (int'(shr) > MAXI)      y = W'(MAXI);
    else if (int'(shr) < MINI) y = W'(MINI);
    else                       y = shr[W-1:0];
  end
endmodule

// File: rtl/snn_sat_add.sv
module snn_sat_add #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int MAXI = 2 ** (W - 1) - 1;
  localparam int MINI = -(2 ** (W - 1));

  logic signed [W:0] s;

  always_comb begin
    s = (W+1)'(a) + (W+1)'(b);
    if (int'(s) > MAXI)      y = W'(MAXI);
    else if (int'(s) < MINI) y = W'(MINI);
    else                     y = s[W-1:0];
  end
endmodule

// File: rtl/snn_lif_ctrl.sv
module snn_lif_ctrl
  import snn_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 4,
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int THRESH  = 64,
  parameter int V_RESET = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          train_en,
  output logic          done,
  input  logic          in_empty,
  input  logic          in_spike,
  output logic          in_pop,
  input  logic          out_full,
  output logic          out_push,
  output logic          out_spike,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int W_BASE  = 0;
  localparam int V_BASE  = N_IN * N_OUT;
  localparam int T_BASE  = V_BASE + N_OUT;
  localparam int T_GAIN  = T_BASE;
  localparam int T_DECAY = T_BASE + 1;
  localparam int T_STEP  = T_BASE + 2;
  localparam int IW      = $clog2(N_IN + 1);
  localparam int JW      = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  ctl_state_t           state;
  logic [IW-1:0]        in_idx, pl_idx, idx_sel;
  logic [JW-1:0]        nj;
  logic [N_IN-1:0]      spk_vec, spk_sh;
  logic signed [DW-1:0] acc [N_OUT];
  logic signed [DW-1:0] w_q, v_q, t_q;
  logic                 train_q;

  logic signed [DW-1:0] syn_prod, acc_sum, leak, v_upd, w_upd;
  logic                 fired, active, last_j;
  logic [AW-1:0]        waddr;

  snn_q_mul   #(.W(DW)) u_syn_mul  (.a(w_q), .b(mem_rdata), .y(syn_prod));
  snn_sat_add #(.W(DW)) u_acc_add  (.a(acc[nj]), .b(syn_prod), .y(acc_sum));
  snn_q_mul   #(.W(DW)) u_leak_mul (.a(v_q), .b(t_q), .y(leak));
  snn_sat_add #(.W(DW)) u_pot_add  (.a(leak), .b(acc[nj]), .y(v_upd));
  snn_sat_add #(.W(DW)) u_wt_add   (.a(w_q), .b(t_q), .y(w_upd));

  always_comb begin
    fired   = int'(v_upd) > THRESH;
    active  = in_spike && (int'(in_idx) < N_IN);
    last_j  = (int'(nj) == N_OUT - 1);
    idx_sel = (state == ST_SYN_W) ? in_idx : pl_idx;
    waddr   = AW'(W_BASE + int'(idx_sel) * N_OUT + int'(nj));
    spk_sh  = spk_vec >> pl_idx;
  end

  // Memory and queue strobes decoded from the state register
  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; mem_addr = '0; mem_wdata = '0;
    in_pop = 1'b0; out_push = 1'b0; out_spike = 1'b0;
    case (state)
      ST_HEAD:    in_pop = !in_empty && !active;
      ST_SYN_W:   begin mem_rd = 1'b1; mem_addr = waddr; end
      ST_SYN_G:   begin mem_rd = 1'b1; mem_addr = AW'(T_GAIN); end
      ST_SYN_ACC: in_pop = last_j;
      ST_NEU_V:   begin mem_rd = 1'b1; mem_addr = AW'(V_BASE + int'(nj)); end
      ST_NEU_D:   begin mem_rd = 1'b1; mem_addr = AW'(T_DECAY); end
      ST_NEU_WR: if (!out_full) begin
        mem_wr    = 1'b1;
        mem_addr  = AW'(V_BASE + int'(nj));
        mem_wdata = fired ? DW'(V_RESET) : v_upd;
        out_push  = 1'b1;
        out_spike = fired;
      end
      ST_PL_W:    begin mem_rd = 1'b1; mem_addr = waddr; end
      ST_PL_D:    begin mem_rd = 1'b1; mem_addr = AW'(T_STEP); end
      ST_PL_WR:   begin mem_wr = 1'b1; mem_addr = waddr; mem_wdata = w_upd; end
      default: ;
    endcase
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      in_idx  <= '0;
      pl_idx  <= '0;
      nj      <= '0;
      spk_vec <= '0;
      w_q     <= '0;
      v_q     <= '0;
      t_q     <= '0;
      train_q <= 1'b0;
      for (int k = 0; k < N_OUT; k++) acc[k] <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          train_q <= train_en;
          in_idx  <= '0;
          spk_vec <= '0;
          for (int k = 0; k < N_OUT; k++) acc[k] <= '0;
          state   <= ST_HEAD;
        end
        ST_HEAD: begin
          if (in_empty) begin
            nj    <= '0;
            state <= ST_NEU_V;
          end else if (active) begin
            spk_vec <= spk_vec | (N_IN'(1) << in_idx);
            nj      <= '0;
            state   <= ST_SYN_W;
          end else if (int'(in_idx) != N_IN) begin
            in_idx <= in_idx + 1'b1;
          end
        end
        ST_SYN_W: state <= ST_SYN_G;
        ST_SYN_G: begin w_q <= mem_rdata; state <= ST_SYN_ACC; end
        ST_SYN_ACC: begin
          acc[nj] <= acc_sum;
          if (last_j) begin
            in_idx <= in_idx + 1'b1;
            state  <= ST_HEAD;
          end else begin
            nj    <= nj + 1'b1;
            state <= ST_SYN_W;
          end
        end
        ST_NEU_V:   state <= ST_NEU_D;
        ST_NEU_D:   begin v_q <= mem_rdata; state <= ST_NEU_CAP; end
        ST_NEU_CAP: begin t_q <= mem_rdata; state <= ST_NEU_WR; end
        ST_NEU_WR: if (!out_full) begin
          if (fired && train_q) begin
            pl_idx <= '0;
            state  <= ST_PL_SCAN;
          end else if (last_j) begin
            state <= ST_DONE;
          end else begin
            nj    <= nj + 1'b1;
            state <= ST_NEU_V;
          end
        end
        ST_PL_SCAN: begin
          if (int'(pl_idx) == N_IN) begin
            if (last_j) state <= ST_DONE;
            else begin nj <= nj + 1'b1; state <= ST_NEU_V; end
          end else if (spk_sh[0]) begin
            state <= ST_PL_W;
          end else begin
            pl_idx <= pl_idx + 1'b1;
          end
        end
        ST_PL_W:   state <= ST_PL_D;
        ST_PL_D:   begin w_q <= mem_rdata; state <= ST_PL_CAP; end
        ST_PL_CAP: begin t_q <= mem_rdata; state <= ST_PL_WR; end
        ST_PL_WR:  begin pl_idx <= pl_idx + 1'b1; state <= ST_PL_SCAN; end
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
    in_pop |-> !in_empty);
  assert_push_notfull_R6: assert property (@(posedge clk) disable iff (rst)
    out_push |-> !out_full);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_no_infer_wt_write_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && int'(mem_addr) < V_BASE) |-> train_q);
endmodule

// File: tb/snn_lif_ctrl_tb.sv
module snn_lif_ctrl_tb;
  localparam int N_IN = 8, N_OUT = 4, DW = 8, AW = 8, THRESH = 64;
  localparam int V_BASE = N_IN * N_OUT;
  localparam int T_BASE = V_BASE + N_OUT;
  localparam int TOP    = T_BASE + 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, train_en = 1'b0, out_full = 1'b0;
  logic done, in_empty, in_spike, in_pop, out_push, out_spike, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  snn_lif_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .AW(AW), .THRESH(THRESH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .train_en(train_en), .done(done),
    .in_empty(in_empty), .in_spike(in_spike), .in_pop(in_pop),
    .out_full(out_full), .out_push(out_push), .out_spike(out_spike),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] pre_mem [256];
  logic       out_q [64];
  logic       in_buf [32];
  int in_wp = 0, in_rp = 0;
  int rd_cnt = 0, wr_cnt = 0, push_cnt = 0, push_full = 0;
  int checks = 0, errors = 0;

  assign in_empty = (in_rp == in_wp);
  assign in_spike = in_buf[in_rp % 32];

  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (in_pop) in_rp <= in_rp + 1;
    if (out_push && out_full) push_full <= push_full + 1;
    if (out_push && !out_full) begin
      out_q[push_cnt % 64] <= out_spike;
      push_cnt <= push_cnt + 1;
    end
  end

  function automatic int sx(logic [7:0] x);
    return int'($signed(x));
  endfunction
  function automatic int sat8(int x);
    return (x > 127) ? 127 : ((x < -128) ? -128 : x);
  endfunction
  function automatic int qmul(int a, int b);
    return sat8((a * b) >>> 7);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run_step(logic [N_IN-1:0] spk, bit train, string req, int stall);
    int acc [N_OUT];
    int eo [N_OUT];
    int act_n = 0, fired_n = 0, rd0, wr0, p0, v, bad, n;
    for (int a = 0; a < 256; a++) begin exp_mem[a] = mem[a]; pre_mem[a] = mem[a]; end
    for (int j = 0; j < N_OUT; j++) acc[j] = 0;
    for (int i = 0; i < N_IN; i++)
      if (spk[i]) begin
        act_n++;
        for (int j = 0; j < N_OUT; j++)
          acc[j] = sat8(acc[j] + qmul(sx(exp_mem[i*N_OUT+j]), sx(exp_mem[T_BASE])));
      end
    for (int j = 0; j < N_OUT; j++) begin
      v = sat8(qmul(sx(exp_mem[V_BASE+j]), sx(exp_mem[T_BASE+1])) + acc[j]);
      if (v > THRESH) begin
        eo[j] = 1; exp_mem[V_BASE+j] = 8'd0; fired_n++;
        if (train)
          for (int i = 0; i < N_IN; i++)
            if (spk[i])
              exp_mem[i*N_OUT+j] = 8'(sat8(sx(exp_mem[i*N_OUT+j]) + sx(exp_mem[T_BASE+2])));
      end else begin
        eo[j] = 0; exp_mem[V_BASE+j] = 8'(v);
      end
    end
    @(negedge clk);
    for (int i = 0; i < N_IN; i++) begin in_buf[in_wp % 32] = spk[i]; in_wp++; end
    rd0 = rd_cnt; wr0 = wr_cnt; p0 = push_cnt;
    train_en = train;
    if (stall > 0) out_full = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (stall > 0 && n == stall) out_full = 1'b0;
      @(negedge clk);
      n++;
    end
    out_full = 1'b0;
    chk(done, "R9", {req, " done reached"}, int'(done), 1);
    @(negedge clk);
    chk(!done, "R9", {req, " done one cycle"}, int'(done), 0);
    bad = 0;
    for (int a = 0; a < TOP; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, req, "memory image mismatches", bad, 0);
    chk(push_cnt - p0 == N_OUT, "R5", {req, " spike count"}, push_cnt - p0, N_OUT);
    bad = 0;
    for (int j = 0; j < N_OUT; j++) if (out_q[(p0 + j) % 64] !== eo[j][0]) bad++;
    chk(bad == 0, "R5", {req, " spike bits mismatches"}, bad, 0);
    chk(rd_cnt - rd0 == 2*act_n*N_OUT + 2*N_OUT + (train ? 2*fired_n*act_n : 0),
        "R9", {req, " read count"}, rd_cnt - rd0,
        2*act_n*N_OUT + 2*N_OUT + (train ? 2*fired_n*act_n : 0));
    chk(wr_cnt - wr0 == N_OUT + (train ? fired_n*act_n : 0),
        "R9", {req, " write count"}, wr_cnt - wr0, N_OUT + (train ? fired_n*act_n : 0));
  endtask

  task automatic set_table(int g, int d, int s);
    mem[T_BASE] = 8'(g); mem[T_BASE+1] = 8'(d); mem[T_BASE+2] = 8'(s);
  endtask

  task automatic test_reset();
    int acts = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (done || in_pop || out_push || mem_rd || mem_wr) acts++;
    end
    chk(acts == 0, "R1", "idle strobes after reset", acts, 0);
  endtask

  task automatic test_zero_input();
    for (int a = 0; a < V_BASE; a++) mem[a] = 8'(a * 13 - 90);
    mem[V_BASE] = 8'(100); mem[V_BASE+1] = 8'(-50);
    mem[V_BASE+2] = 8'(20); mem[V_BASE+3] = 8'(70);
    set_table(90, 115, 3);
    run_step(8'h00, 1'b0, "R2 R4 zero input", 0);
  endtask

  task automatic test_infer();
    for (int i = 0; i < N_IN; i++)
      for (int j = 0; j < N_OUT; j++) mem[i*N_OUT+j] = 8'(((i*29 + j*47 + 11) % 200) - 100);
    mem[V_BASE] = 8'(10); mem[V_BASE+1] = 8'(40);
    mem[V_BASE+2] = 8'(-20); mem[V_BASE+3] = 8'(60);
    set_table(100, 112, 5);
    run_step(8'b1010_0110, 1'b0, "R3 R11 inference", 0);
    begin
      int bad = 0;
      for (int a = 0; a < V_BASE; a++) if (mem[a] !== pre_mem[a]) bad++;
      chk(bad == 0, "R7", "weights changed in inference", bad, 0);
    end
  endtask

  task automatic test_train_fire();
    for (int j = 0; j < N_OUT; j++) mem[V_BASE+j] = 8'(120 - j*60);
    set_table(100, 127, 7);
    run_step(8'b0011_0101, 1'b1, "R8 training with firing", 0);
  endtask

  task automatic test_train_quiet();
    for (int a = 0; a < V_BASE; a++) mem[a] = 8'(-50);
    for (int j = 0; j < N_OUT; j++) mem[V_BASE+j] = 8'(-100);
    set_table(100, 100, 9);
    run_step(8'hFF, 1'b1, "R8 training without firing", 0);
  endtask

  task automatic test_saturate();
    int bad = 0;
    for (int a = 0; a < V_BASE; a++) mem[a] = 8'h80;
    for (int j = 0; j < N_OUT; j++) mem[V_BASE+j] = 8'h80;
    set_table(127, 127, 1);
    run_step(8'hFF, 1'b0, "R10 negative saturation", 0);
    for (int j = 0; j < N_OUT; j++) if (mem[V_BASE+j] !== 8'h80) bad++;
    chk(bad == 0, "R10", "potentials not clamped to -128", bad, 0);
  endtask

  task automatic test_stall();
    int pf0 = push_full;
    for (int i = 0; i < N_IN; i++)
      for (int j = 0; j < N_OUT; j++) mem[i*N_OUT+j] = 8'((i + 1) * (j + 3) * 5);
    for (int j = 0; j < N_OUT; j++) mem[V_BASE+j] = 8'(30 + j*25);
    set_table(80, 127, 2);
    run_step(8'b1000_0001, 1'b0, "R6 output stall", 150);
    chk(push_full - pf0 == 0, "R6", "pushes while full", push_full - pf0, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'd0;
    for (int k = 0; k < 32; k++) in_buf[k] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_zero_input();
    test_infer();
    test_train_fire();
    test_train_quiet();
    test_saturate();
    test_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule